// File: doc/BRIEF.md
# Serial Receive Byte Queue

This block is a small first-in, first-out store for characters arriving from a serial line receiver. The receiver side offers one byte per cycle on a push port. Register reads of the receive data location drive a pop port, which returns the oldest stored byte in the same cycle it is requested. The block derives the data-available and queue-full status flags. It also produces an accept hint that tells the line receiver whether another character may be taken.

A line-break condition is handled inside the queue. A break stores a zero byte and sets a sticky delta-break flag that stays set until a clear request. When the queue is already full, an incoming byte or break replaces the most recently stored entry, so a break is never lost. A receiver-reset input empties the queue without touching the break flag.

Top module: `serial_rx_queue`

## Requirements
- R1: The queue holds DEPTH bytes (default 4), and pops return bytes in the order they were pushed, oldest first.
- R2: Any accepted push makes `data_ready` high from the following cycle. `queue_full` is high exactly when DEPTH bytes are held, and it implies `data_ready`.
- R3: A push (data or break) without a pop while the queue is full replaces the newest entry. The older DEPTH-1 entries are kept and the queue stays full.
- R4: A `brk_event` enqueues the byte 0x00 and sets `brk_flag` from the next cycle. If `push_valid` is high in the same cycle, the break wins and `push_data` is not stored.
- R5: A pop while the queue is empty returns 0x00 on `pop_data` and leaves the stored contents and flags unchanged.
- R6: A pop with no push clears `queue_full` if it was set. The pop that removes the last byte clears `data_ready`.
- R7: `can_accept` is high only when `rx_enable` is high and `queue_full` is low.
- R8: `rx_flush` empties the queue and clears `data_ready` and `queue_full` on the next cycle, overriding any push or pop in the same cycle. `brk_flag` is not affected by the flush.
- R9: A push and a pop in the same cycle return the oldest byte, append the new one, and leave the count unchanged. On an empty queue, the pop returns 0x00 and the new byte is stored.
- R10: `brk_clear` clears `brk_flag` from the next cycle. When `brk_event` and `brk_clear` coincide, the flag is set.
- R11: Pushes are stored whether or not `rx_enable` is high; `rx_enable` only affects `can_accept`.
- R12: After reset the queue is empty and `data_ready`, `queue_full` and `brk_flag` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_enable | input | 1 | Receiver enabled; gates the accept hint |
| rx_flush | input | 1 | Receiver reset: empties the queue |
| push_valid | input | 1 | Line receiver delivers a byte |
| push_data | input | DATA_W | Byte from the line receiver |
| brk_event | input | 1 | Line break detected: store 0x00 and set the break flag |
| brk_clear | input | 1 | Clear the sticky break flag |
| pop_req | input | 1 | Read of the receive data location |
| pop_data | output | DATA_W | Oldest byte, or 0x00 when empty (valid in the cycle of the pop) |
| data_ready | output | 1 | Queue holds at least one byte |
| queue_full | output | 1 | Queue holds DEPTH bytes |
| can_accept | output | 1 | Line receiver may deliver another byte |
| brk_flag | output | 1 | Sticky delta-break flag |

## Verification
The bound checker watches the flag relations on every cycle:
- full implies ready, and full blocks the accept hint;
- a push raises ready, and a flush drops ready and full;
- an empty pop reads zero and changes nothing;
- a full push keeps the queue full, and a lone pop from full clears full;
- the break flag sets on a break and holds until it is cleared.

Byte ordering can only be shown by the bench's directed scenarios, because it depends on sequences of values rather than on flags. These include which entry a full-queue overwrite replaces, that a break's zero lands in order, that simultaneous push and pop keep the sequence, and that a flush discards contents.

// File: rtl/serial_rx_queue_pkg.sv
package serial_rx_queue_pkg;
  localparam int unsigned RXQ_DEPTH_DEF  = 4;
  localparam int unsigned RXQ_DATA_W_DEF = 8;

  // Source of the byte written into the queue in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LINE  = 2'd1,
    SRC_BREAK = 2'd2
  } rxq_src_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0][DATA_W-1:0] entries;

  // One enabled register per slot; slots carry no reset, contents are
  // only observed after a write has made them valid.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = wr_en && (wr_addr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q <= wr_data;
      end
    end
    assign entries[g] = slot_q;
  end

  assign rd_data = entries[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import serial_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              brk_event,
  input  logic              pop_req,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              is_empty,
  output logic              is_full
);
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rxq_src_e         src;
  logic             do_push, do_pop, overwrite, advance;

  always_comb begin
    if (brk_event)       src = SRC_BREAK;
    else if (push_valid) src = SRC_LINE;
    else                 src = SRC_NONE;
  end

  assign is_empty  = (cnt_q == '0);
  assign is_full   = (cnt_q == CNT_W'(DEPTH));
  assign do_push   = (src != SRC_NONE);
  assign do_pop    = pop_req && !is_empty;
  assign overwrite = do_push && is_full && !do_pop;
  assign advance   = do_push && !overwrite;

  assign wr_en   = do_push && !flush;
  assign wr_addr = overwrite ? (wr_ptr_q - PTR_W'(1)) : wr_ptr_q;
  assign wr_data = (src == SRC_BREAK) ? '0 : push_data;
  assign rd_addr = rd_ptr_q;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_pop)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
      if (advance) wr_ptr_d = wr_ptr_q + PTR_W'(1);
      if (advance && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
      else if (!advance && do_pop) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/rxq_break_flag.sv
module rxq_break_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH_DEF,
  parameter int unsigned DATA_W = RXQ_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              brk_event,
  input  logic              brk_clear,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              data_ready,
  output logic              queue_full,
  output logic              can_accept,
  output logic              brk_flag
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic              rst_meta_n, rst_sync_n;
  logic              wr_en, is_empty, is_full;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rxq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (rx_flush),
    .push_valid (push_valid),
    .push_data  (push_data),
    .brk_event  (brk_event),
    .pop_req    (pop_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .is_empty   (is_empty),
    .is_full    (is_full)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  rxq_break_flag brk_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (brk_event),
    .clr   (brk_clear),
    .flag  (brk_flag)
  );

  assign pop_data   = is_empty ? '0 : rd_data;
  assign data_ready = !is_empty;
  assign queue_full = is_full;
  assign can_accept = rx_enable && !is_full;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              rx_flush,
  input logic              push_valid,
  input logic              brk_event,
  input logic              brk_clear,
  input logic              pop_req,
  input logic [DATA_W-1:0] pop_data,
  input logic              data_ready,
  input logic              queue_full,
  input logic              can_accept,
  input logic              brk_flag
);
  assert_full_implies_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |-> data_ready);

  assert_push_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || brk_event) && !rx_flush |=> data_ready);

  assert_overwrite_stays_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full && (push_valid || brk_event) && !pop_req && !rx_flush |=> queue_full);

  assert_break_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |=> brk_flag);

  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready && pop_req |-> pop_data == '0);

  assert_empty_pop_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready && pop_req && !push_valid && !brk_event |=> !data_ready);

  assert_pop_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full && pop_req && !push_valid && !brk_event |=> !queue_full);

  assert_full_blocks_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |-> !can_accept);

  assert_disabled_blocks_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !can_accept);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !data_ready && !queue_full);

  assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !brk_clear |=> brk_flag);
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rx_enable  (rx_enable),
  .rx_flush   (rx_flush),
  .push_valid (push_valid),
  .brk_event  (brk_event),
  .brk_clear  (brk_clear),
  .pop_req    (pop_req),
  .pop_data   (pop_data),
  .data_ready (data_ready),
  .queue_full (queue_full),
  .can_accept (can_accept),
  .brk_flag   (brk_flag)
);

// File: tb/serial_rx_queue_tb_top.sv
`timescale 1ns/1ps
module serial_rx_queue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_enable = 1'b0;
  logic       rx_flush = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       brk_event = 1'b0;
  logic       brk_clear = 1'b0;
  logic       pop_req = 1'b0;
  logic [7:0] pop_data;
  logic       data_ready, queue_full, can_accept, brk_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] last_pop;

  always #2 clk = ~clk;

  serial_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_flush(rx_flush),
    .push_valid(push_valid), .push_data(push_data), .brk_event(brk_event),
    .brk_clear(brk_clear), .pop_req(pop_req), .pop_data(pop_data),
    .data_ready(data_ready), .queue_full(queue_full),
    .can_accept(can_accept), .brk_flag(brk_flag)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One cycle of stimulus: drive after a falling edge, capture pop_data
  // before the rising edge, return at the next falling edge with inputs idle.
  task automatic step(input bit pv, input logic [7:0] pd, input bit brk,
                      input bit pop, input bit fl, input bit bclr);
    push_valid = pv; push_data = pd; brk_event = brk;
    pop_req = pop; rx_flush = fl; brk_clear = bclr;
    #1 last_pop = pop_data;
    @(negedge clk);
    push_valid = 0; push_data = 8'h00; brk_event = 0;
    pop_req = 0; rx_flush = 0; brk_clear = 0;
  endtask

  task automatic push(input logic [7:0] b);
    step(1, b, 0, 0, 0, 0);
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string what);
    step(0, 8'h00, 0, 1, 0, 0);
    chk(last_pop, exp, what);
  endtask

  task automatic t_reset;
    chk({7'd0, data_ready}, 8'd0, "R12 ready after reset");
    chk({7'd0, queue_full}, 8'd0, "R12 full after reset");
    chk({7'd0, brk_flag},   8'd0, "R12 break flag after reset");
    chk({7'd0, can_accept}, 8'd0, "R7 accept low while disabled");
  endtask

  task automatic t_order;
    rx_enable = 1;
    push(8'h11);
    chk({7'd0, data_ready}, 8'd1, "R2 ready after first push");
    chk({7'd0, can_accept}, 8'd1, "R7 accept when enabled and not full");
    push(8'h22); push(8'h33);
    chk({7'd0, queue_full}, 8'd0, "R2 not full at three");
    push(8'h44);
    chk({7'd0, queue_full}, 8'd1, "R2 full at four");
    chk({7'd0, can_accept}, 8'd0, "R7 accept low when full");
    pop_expect(8'h11, "R1 first pop oldest");
    chk({7'd0, queue_full}, 8'd0, "R6 pop clears full");
    pop_expect(8'h22, "R1 second pop");
    pop_expect(8'h33, "R1 third pop");
    chk({7'd0, data_ready}, 8'd1, "R6 ready while one left");
    pop_expect(8'h44, "R1 fourth pop");
    chk({7'd0, data_ready}, 8'd0, "R6 last pop clears ready");
  endtask

  task automatic t_overwrite;
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    push(8'h55);
    chk({7'd0, queue_full}, 8'd1, "R3 still full after overwrite");
    step(0, 8'h00, 1, 0, 0, 0);
    chk({7'd0, queue_full}, 8'd1, "R3 still full after break overwrite");
    pop_expect(8'hA1, "R3 oldest kept");
    pop_expect(8'hA2, "R3 second kept");
    pop_expect(8'hA3, "R3 third kept");
    pop_expect(8'h00, "R3 newest replaced by break zero");
    chk({7'd0, data_ready}, 8'd0, "R3 empty after four pops");
    step(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_break;
    push(8'hB1);
    step(1, 8'h77, 1, 0, 0, 0);
    chk({7'd0, brk_flag}, 8'd1, "R4 break sets flag");
    pop_expect(8'hB1, "R4 byte before break");
    pop_expect(8'h00, "R4 break stores zero, line byte dropped");
    chk({7'd0, data_ready}, 8'd0, "R4 only one entry from break cycle");
    step(0, 8'h00, 0, 0, 0, 1);
    chk({7'd0, brk_flag}, 8'd0, "R10 clear drops flag");
    step(0, 8'h00, 1, 0, 0, 1);
    chk({7'd0, brk_flag}, 8'd1, "R10 set wins over clear");
    pop_expect(8'h00, "R4 zero from coinciding break");
    step(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_empty_pop;
    pop_expect(8'h00, "R5 empty pop reads zero");
    chk({7'd0, data_ready}, 8'd0, "R5 empty pop keeps ready low");
    push(8'h9C);
    pop_expect(8'h9C, "R5 pointers untouched by empty pop");
  endtask

  task automatic t_simul;
    push(8'hC1); push(8'hC2);
    step(1, 8'hC3, 0, 1, 0, 0);
    chk(last_pop, 8'hC1, "R9 simultaneous pop returns oldest");
    pop_expect(8'hC2, "R9 order after simultaneous op");
    pop_expect(8'hC3, "R9 appended byte");
    chk({7'd0, data_ready}, 8'd0, "R9 count unchanged by simultaneous op");
    step(1, 8'hD5, 0, 1, 0, 0);
    chk(last_pop, 8'h00, "R9 empty simultaneous pop reads zero");
    chk({7'd0, data_ready}, 8'd1, "R9 empty simultaneous push stored");
    pop_expect(8'hD5, "R9 stored byte from empty simultaneous op");
  endtask

  task automatic t_flush;
    step(0, 8'h00, 1, 0, 0, 0);
    push(8'hE1); push(8'hE2);
    step(1, 8'hE3, 0, 1, 1, 0);
    chk({7'd0, data_ready}, 8'd0, "R8 flush clears ready");
    chk({7'd0, queue_full}, 8'd0, "R8 flush clears full");
    chk({7'd0, brk_flag},   8'd1, "R8 flush keeps break flag");
    pop_expect(8'h00, "R8 nothing left after flush");
    push(8'hE4);
    pop_expect(8'hE4, "R8 queue usable after flush");
    step(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic t_disabled;
    rx_enable = 0;
    push(8'hF1);
    chk({7'd0, data_ready}, 8'd1, "R11 push stored while disabled");
    chk({7'd0, can_accept}, 8'd0, "R7 accept low while disabled");
    pop_expect(8'hF1, "R11 byte stored while disabled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_overwrite();
    t_break();
    t_empty_pop();
    t_simul();
    t_flush();
    t_disabled();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule